// File: doc/BRIEF.md
# Row-Buffered Write Controller with Write Guard

This block sits behind the serial slave engine of a byte-addressed non-volatile memory and turns the write commands it decodes into array updates. The engine hands it bus events: the start and stop conditions, the address byte, each received data byte, each sampled bit and the end of each acknowledge slot. The block collects the data bytes into a one-row buffer with a per-byte valid mask and tells the engine, for each byte, whether to acknowledge it.

When a stop condition arrives directly after a data-byte acknowledge slot, the block runs a self-timed programming cycle. It copies only the buffered bytes into their row of the array. A `busy` flag stays high for a fixed number of clock cycles. While it is high the block ignores every bus event, so the engine can stay silent and the bus master can poll with select bytes until one is acknowledged again.

A guard input held high at any point between the start condition and the address byte blocks the whole command. The data bytes are then not acknowledged and nothing is written. A read port into the array works whatever the guard level.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset `busy`, `byte_ack` and `mem_we` are 0, and every array location reads 8'hFF.
- R2: With `wc_in` low during the protect window, every data byte sets `byte_ack` to 1 from the clock edge after its `data_stb`. A single byte and a multi-byte page go through the same path.
- R3: If `wc_in` is 1 in any cycle from `start_ev` up to and including the `addr_stb` cycle, each later data byte drives `byte_ack` to 0 and the array is not written.
- R4: The buffer column is the low `PG_W` bits of the address. It advances by one per data byte and wraps from 15 to 0 inside the same row (the upper address bits do not change). A later byte at a column overwrites the earlier one.
- R5: A programming cycle writes only the columns that received a byte. It writes them in ascending column order, all in one row, and only while `busy` is 1. The other locations keep their values.
- R6: A programming cycle starts only when `stop_ev` comes with no `bit_stb`, `data_stb` or other event after the last `ack_done`. Any other stop discards the buffer.
- R7: A `start_ev` that arrives after bytes are buffered and before a valid stop empties the buffer, and no programming follows.
- R8: `busy` rises on the edge that accepts the committing stop and stays 1 for exactly `PROG_CYC` cycles. While `busy` is 1, all bus events are ignored.
- R9: Once `busy` has fallen, the next write command is accepted and programmed normally.
- R10: `rd_data` returns the array byte at `rd_addr` one cycle after `rd_addr` is sampled, at any `wc_in` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wc_in | input | 1 | Write guard, high blocks writes |
| start_ev | input | 1 | Start or repeated start seen (pulse) |
| stop_ev | input | 1 | Stop condition seen (pulse) |
| addr_stb | input | 1 | Address byte of a write command received (pulse) |
| addr_in | input | ADDR_W | Byte address carried with `addr_stb` |
| bit_stb | input | 1 | A data bit was sampled (pulse) |
| data_stb | input | 1 | Data byte received (pulse) |
| data_in | input | DATA_W | Data byte carried with `data_stb` |
| ack_done | input | 1 | Acknowledge slot of a data byte finished (pulse) |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Registered array read data |
| byte_ack | output | 1 | Acknowledge decision for the latest data byte |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Programming cycle in progress |

## Verification
Each event input is sampled on a rising edge, and `byte_ack` and `busy` change on that same edge. The first `mem_we` of a programming cycle appears one edge after the committing stop, and the array holds the new byte one edge after that strobe. A read answers on the edge after `rd_addr` is sampled. The bench drives inputs on falling edges and runs a behavioural model on the rising edges. It compares `busy`, `byte_ack` and every write strobe at the next falling edge, and it compares read data one full cycle after the address is applied, once `busy` has fallen.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_PROG = 1'b1
  } pgwr_state_e;

endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
  parameter int DATA_W = 8,
  parameter int PG_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld_ptr,
  input  logic [PG_W-1:0]   ptr_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PG_W-1:0]   rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);

  localparam int PAGE = 1 << PG_W;

  logic [DATA_W-1:0] row_buf [PAGE];
  logic [PAGE-1:0]   mask_q;
  logic [PG_W-1:0]   ptr_q;

  // mask and column pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ptr_q  <= '0;
    end else if (clr) begin
      mask_q <= '0;
    end else begin
      if (ld_ptr) begin
        ptr_q <= ptr_in;
      end else if (wr_en) begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
      end
    end
  end

  // data storage, no reset needed
  always_ff @(posedge clk) begin
    if (wr_en && !ld_ptr && !clr) begin
      row_buf[ptr_q] <= wr_data;
    end
  end

  assign rd_data = row_buf[rd_idx];
  assign rd_vld  = mask_q[rd_idx];
  assign any_vld = |mask_q;

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CW'(CYC - 1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int PG_W     = 4,
  parameter int PROG_CYC = 2_500_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wc_in,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              bit_stb,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] data_in,
  input  logic              ack_done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              byte_ack,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);

  localparam int ROW_W = ADDR_W - PG_W;

  pgwr_state_e       st_q;
  logic              busy_q;
  logic              win_q;
  logic              prot_q;
  logic              aok_q;
  logic              armed_q;
  logic [ROW_W-1:0]  row_q;
  logic [PG_W-1:0]   idx_q;
  logic              seq_on_q;
  logic              ack_q;
  logic              we_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  logic              act;
  logic              commit;
  logic              prog_end;
  logic              tmr_zero;
  logic              lat_clr;
  logic              lat_wr;
  logic [DATA_W-1:0] lat_rdata;
  logic              lat_rvld;
  logic              lat_any;

  // bus events are only honoured when no programming cycle runs
  assign act      = !busy_q;
  assign commit   = act && stop_ev && armed_q && lat_any && !prot_q;
  assign prog_end = (st_q == ST_PROG) && tmr_zero;
  assign lat_clr  = (act && start_ev) || (act && stop_ev && !commit) || prog_end;
  assign lat_wr   = act && data_stb && aok_q && !prot_q && !start_ev && !stop_ev;

  pgwr_latch #(
    .DATA_W (DATA_W),
    .PG_W   (PG_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .clr     (lat_clr),
    .ld_ptr  (act && addr_stb && !start_ev && !stop_ev),
    .ptr_in  (addr_in[PG_W-1:0]),
    .wr_en   (lat_wr),
    .wr_data (data_in),
    .rd_idx  (idx_q),
    .rd_data (lat_rdata),
    .rd_vld  (lat_rvld),
    .any_vld (lat_any)
  );

  pgwr_timer #(
    .CYC (PROG_CYC)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (commit),
    .zero (tmr_zero)
  );

  pgwr_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk   (clk),
    .we    (we_q),
    .waddr (wa_q),
    .wdata (wd_q),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // command tracking: protect window, address, ack decision, stop qualification
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      prot_q  <= 1'b0;
      aok_q   <= 1'b0;
      armed_q <= 1'b0;
      ack_q   <= 1'b0;
      row_q   <= '0;
    end else if (act) begin
      if (stop_ev) begin
        win_q   <= 1'b0;
        aok_q   <= 1'b0;
        armed_q <= 1'b0;
      end else if (start_ev) begin
        win_q   <= 1'b1;
        prot_q  <= wc_in;
        aok_q   <= 1'b0;
        armed_q <= 1'b0;
        ack_q   <= 1'b0;
      end else begin
        if (win_q) begin
          prot_q <= prot_q | wc_in;
        end
        if (addr_stb) begin
          win_q   <= 1'b0;
          aok_q   <= 1'b1;
          armed_q <= 1'b0;
          row_q   <= addr_in[ADDR_W-1:PG_W];
        end else if (data_stb) begin
          armed_q <= 1'b0;
          if (aok_q) begin
            ack_q <= !prot_q;
          end
        end else if (bit_stb) begin
          armed_q <= 1'b0;
        end else if (ack_done && aok_q) begin
          armed_q <= 1'b1;
        end
      end
    end
  end

  // programming sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      busy_q   <= 1'b0;
      idx_q    <= '0;
      seq_on_q <= 1'b0;
      we_q     <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      we_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (commit) begin
            st_q     <= ST_PROG;
            busy_q   <= 1'b1;
            idx_q    <= '0;
            seq_on_q <= 1'b1;
          end
        end
        ST_PROG: begin
          if (seq_on_q) begin
            we_q  <= lat_rvld;
            wa_q  <= {row_q, idx_q};
            wd_q  <= lat_rdata;
            idx_q <= idx_q + 1'b1;
            if (idx_q == {PG_W{1'b1}}) begin
              seq_on_q <= 1'b0;
            end
          end
          if (tmr_zero) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = busy_q;
  assign byte_ack  = ack_q;
  assign mem_we    = we_q;
  assign mem_waddr = wa_q;
  assign mem_wdata = wd_q;

endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int ADDR_W = 10,
  parameter int PG_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stop_ev,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic              tmr_zero
);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_ev));

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(tmr_zero));

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R4
  one_row_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && busy && $past(busy) && $past(mem_we)) |->
      (mem_waddr[ADDR_W-1:PG_W] == $past(mem_waddr[ADDR_W-1:PG_W])));

  // R5
  col_order_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && busy && $past(busy) && $past(mem_we)) |->
      (mem_waddr[PG_W-1:0] > $past(mem_waddr[PG_W-1:0])));

endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .PG_W   (PG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stop_ev   (stop_ev),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_waddr (mem_waddr),
  .tmr_zero  (tmr_zero)
);

// File: tb/pgwr_ctrl_test.sv
module pgwr_ctrl_test;

  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int PW  = 4;
  localparam int PC  = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wc_in = 1'b0;
  logic          start_ev = 1'b0;
  logic          stop_ev = 1'b0;
  logic          addr_stb = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          bit_stb = 1'b0;
  logic          data_stb = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          ack_done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          byte_ack;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic          busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pgwr_ctrl #(
    .ADDR_W (AW), .DATA_W (DW), .PG_W (PW), .PROG_CYC (PC)
  ) uut (
    .clk (clk), .rst (rst), .wc_in (wc_in), .start_ev (start_ev),
    .stop_ev (stop_ev), .addr_stb (addr_stb), .addr_in (addr_in),
    .bit_stb (bit_stb), .data_stb (data_stb), .data_in (data_in),
    .ack_done (ack_done), .rd_addr (rd_addr), .rd_data (rd_data),
    .byte_ack (byte_ack), .mem_we (mem_we), .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata), .busy (busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int ref_mem [1 << AW];
  int exp_q [$];
  int m_left = 0;
  bit m_win = 0, m_prot = 0, m_aok = 0, m_armed = 0, m_ack = 0;
  int m_row = 0, m_col = 0;
  int pg_dat [16];
  bit pg_vld [16];

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'hFF;
    for (int i = 0; i < 16; i++) pg_vld[i] = 0;
  end

  function automatic void m_clear();
    for (int i = 0; i < 16; i++) pg_vld[i] = 0;
  endfunction

  function automatic bit m_any();
    for (int i = 0; i < 16; i++) if (pg_vld[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_win = 0; m_prot = 0; m_aok = 0; m_armed = 0; m_ack = 0;
      m_clear();
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_clear();
    end else if (stop_ev) begin
      if (m_armed && !m_prot && m_any()) begin
        for (int c = 0; c < 16; c++) begin
          if (pg_vld[c]) begin
            exp_q.push_back((m_row * 16 + c) * 256 + pg_dat[c]);
            ref_mem[m_row * 16 + c] = pg_dat[c];
          end
        end
        m_left = PC;
      end else begin
        m_clear();
      end
      m_win = 0; m_aok = 0; m_armed = 0;
    end else if (start_ev) begin
      m_win = 1; m_prot = wc_in; m_aok = 0; m_armed = 0; m_ack = 0;
      m_clear();
    end else begin
      if (m_win && wc_in) m_prot = 1;
      if (addr_stb) begin
        m_win = 0; m_aok = 1; m_armed = 0;
        m_row = int'(addr_in) / 16; m_col = int'(addr_in) % 16;
      end else if (data_stb) begin
        m_armed = 0;
        if (m_aok) begin
          m_ack = !m_prot;
          if (!m_prot) begin
            pg_dat[m_col] = int'(data_in); pg_vld[m_col] = 1;
            m_col = (m_col + 1) % 16;
          end
        end
      end else if (bit_stb) begin
        m_armed = 0;
      end else if (ack_done && m_aok) begin
        m_armed = 1;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(busy == (m_left > 0), "R8 busy vs model", int'(busy), int'(m_left > 0));
      chk(byte_ack == m_ack, "R2 R3 byte_ack vs model", int'(byte_ack), int'(m_ack));
      if (mem_we) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected write", int'(mem_waddr), 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(mem_waddr) * 256 + int'(mem_wdata) == e, "R4 R5 write addr/data",
              int'(mem_waddr) * 256 + int'(mem_wdata), e);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pulse_start();
    @(negedge clk) start_ev = 1; @(negedge clk) start_ev = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk) stop_ev = 1; @(negedge clk) stop_ev = 0;
  endtask
  task automatic pulse_bit();
    @(negedge clk) bit_stb = 1; @(negedge clk) bit_stb = 0;
  endtask
  task automatic send_addr(input int a);
    @(negedge clk) begin addr_stb = 1; addr_in = AW'(a); end
    @(negedge clk) addr_stb = 0;
  endtask
  task automatic send_byte(input int d);
    pulse_bit();
    @(negedge clk) begin data_stb = 1; data_in = DW'(d); end
    @(negedge clk) begin data_stb = 0; ack_done = 1; end
    @(negedge clk) ack_done = 0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 4 * PC && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all writes issued", exp_q.size(), 0);
  endtask
  task automatic rd_chk(input int a, input string tag);
    @(negedge clk) rd_addr = AW'(a);
    @(negedge clk);
    chk(int'(rd_data) == ref_mem[a], tag, int'(rd_data), ref_mem[a]);
  endtask

  initial begin
    #400_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    chk(byte_ack == 0, "R1 byte_ack after reset", int'(byte_ack), 0);
    chk(mem_we == 0, "R1 mem_we after reset", int'(mem_we), 0);
    rd_chk(10'h123, "R1 erased content");

    // R2 single byte
    pulse_start(); send_addr(10'h045); send_byte(8'hA5);
    chk(byte_ack == 1, "R2 single byte acked", int'(byte_ack), 1);
    pulse_stop();
    chk(busy == 1, "R8 busy after stop", int'(busy), 1);
    wait_idle();
    rd_chk(10'h045, "R2 byte written");
    rd_chk(10'h046, "R5 neighbour untouched");

    // R2 R5 short page
    pulse_start(); send_addr(10'h0F2);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
    pulse_stop(); wait_idle();
    rd_chk(10'h0F4, "R2 page byte three");
    rd_chk(10'h0F1, "R5 column before start kept");

    // R4 wrap inside the row, 18 bytes from column 14
    pulse_start(); send_addr(10'h1FE);
    for (int k = 0; k < 18; k++) send_byte(8'h40 + k);
    pulse_stop(); wait_idle();
    rd_chk(10'h1FE, "R4 column 14 overwritten");
    rd_chk(10'h1F0, "R4 wrapped to column 0");
    rd_chk(10'h200, "R4 next row untouched");

    // R3 guard high only at start, low for data
    @(negedge clk) wc_in = 1;
    pulse_start();
    @(negedge clk) wc_in = 0;
    send_addr(10'h045); send_byte(8'h5A);
    chk(byte_ack == 0, "R3 data byte not acked", int'(byte_ack), 0);
    pulse_stop();
    chk(busy == 0, "R3 no programming", int'(busy), 0);
    @(negedge clk) wc_in = 1;
    rd_chk(10'h045, "R10 read with guard high");
    @(negedge clk) wc_in = 0;

    // R6 stop mid-byte discards
    pulse_start(); send_addr(10'h300); send_byte(8'h77); pulse_bit(); pulse_stop();
    chk(busy == 0, "R6 stop after bit no cycle", int'(busy), 0);
    rd_chk(10'h300, "R6 location unchanged");

    // R7 repeated start clears buffer
    pulse_start(); send_addr(10'h310); send_byte(8'h88);
    pulse_start(); pulse_stop();
    chk(busy == 0, "R7 restart discards", int'(busy), 0);
    rd_chk(10'h310, "R7 location unchanged");

    // R8 traffic during busy ignored, R9 accepted afterwards
    pulse_start(); send_addr(10'h020); send_byte(8'hC3); pulse_stop();
    pulse_start(); send_addr(10'h021); send_byte(8'h3C); pulse_stop();
    wait_idle();
    rd_chk(10'h021, "R8 ignored during busy");
    pulse_start(); send_addr(10'h021); send_byte(8'h3C); pulse_stop();
    chk(busy == 1, "R9 accepted after busy", int'(busy), 1);
    wait_idle();
    rd_chk(10'h021, "R9 written after poll");
    rd_chk(10'h020, "R2 earlier write kept");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule